// File: doc/BRIEF.md
# USB Slave Command and Streaming Controller

This block sits in the clock domain of an external USB bridge that works as a synchronous slave FIFO with a 16-bit data bus. The bridge supplies the clock. The controller pulls 16-bit command words from the host-to-device side of the bridge and acts on three codes. It can reply with a six-byte image descriptor, and it can turn a stream request toward the camera capture logic on or off. While the stream is on, it moves words from the pixel FIFO read port onto the device-to-host side of the bus.

The descriptor goes out as three 16-bit words, with the low byte first in each word. The first word holds the image type code in its low byte and a zero reserved byte in its high byte. The second word is the image width and the third is the image height. All three values come from parameters.

The stream request also crosses into the pixel clock domain through a two-flop synchronizer.

Top module: `usb_stream_ctrl`

## Requirements
- R1: `rdEn` is high only in a cycle where `notEmpty` is high. In the waiting and streaming states, `rdEn` equals `notEmpty`, so one command word is taken per cycle.
- R2: Reading the word 0x0101 produces exactly three written words, in order. The first is {8'h00, type}, where type is 0xAA for grayscale and 0xBB for RGB565. The second is the width and the third is the height. Within each word, bits [7:0] form the byte sent first.
- R3: `wrEn` is high only when `notFull` is high in that cycle and was also high in each of the two cycles before it.
- R4: Reading 0x1111 sets `streamReq` from the next cycle onward. Reading 0x0f0f clears it. Repeating either command has no further effect.
- R5: Any other command word leaves `streamReq` unchanged and writes nothing. The controller keeps accepting commands.
- R6: While streaming, each write carries the current pixel FIFO head word, with `fifoRd` high in the same cycle. Words leave in FIFO order. No pixel word is written while the stream is off.
- R7: While streaming, a command read takes priority over a pixel write. `rdEn` and `wrEn` are never high together.
- R8: A parameter query received during streaming inserts the three-word reply. After the reply, pixel forwarding resumes without a new start command.
- R9: `streamStartPix` follows `streamReq` through two flops clocked by `pixClk`.
- R10: During and right after reset, `rdEn`, `wrEn`, `fifoRd`, `streamReq` and `busDataOut` are all zero.
- R11: No command word is read while a reply is in progress. `busDataOut` is zero whenever `wrEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge-supplied bus clock |
| rstN | input | 1 | Active-low reset, bus domain |
| notEmpty | input | 1 | Bridge has a host command word available |
| notFull | input | 1 | Bridge can accept a device word |
| busDataIn | input | 16 | Command word at the head of the bridge's inbound FIFO |
| rdEn | output | 1 | Pop the inbound command word this cycle |
| wrEn | output | 1 | Push `busDataOut` to the bridge this cycle |
| busDataOut | output | 16 | Outbound word (reply or pixel) |
| fifoData | input | 16 | Head word of the pixel FIFO (show-ahead) |
| fifoEmpty | input | 1 | Pixel FIFO has no word |
| fifoRd | output | 1 | Pop the pixel FIFO this cycle |
| streamReq | output | 1 | Stream-on request, bus domain |
| pixClk | input | 1 | Pixel clock |
| pixRstN | input | 1 | Active-low reset, pixel domain |
| streamStartPix | output | 1 | Stream-on request synchronized to `pixClk` |

## Verification
The assertions check these properties on every bus cycle:
- reads are gated by the not-empty flag;
- writes are gated by three cycles of the not-full flag;
- a read and a write never happen in the same cycle;
- pixel pops happen only together with a write from a non-empty FIFO;
- the stream request changes only in the cycle after a command read.

Some behaviours can only be shown by the bench's scenarios, which compare the design against a behavioural model on every clock:
- the content and order of the reply words;
- that unknown codes are ignored;
- that a query inserted mid-stream resumes pixel flow;
- that pixels arrive in order under a toggling not-full flag;
- that the request arrives in the pixel domain.

// File: rtl/usc_pkg.sv
package usc_pkg;
  localparam int CMD_W = 16;
  localparam logic [CMD_W-1:0] CODE_QUERY = 16'h0101;
  localparam logic [CMD_W-1:0] CODE_START = 16'h1111;
  localparam logic [CMD_W-1:0] CODE_STOP  = 16'h0f0f;
  localparam int REPLY_WORDS = 3;

  typedef enum logic [1:0] {CMD_NONE, CMD_QUERY, CMD_START, CMD_STOP} cmdKind_t;
  typedef enum logic [1:0] {S_WAIT, S_REPLY, S_STREAM} ctrlState_t;

  typedef struct packed {
    logic       sendReply;
    logic [1:0] wordSel;
    logic       sendPixel;
  } dpCtrl_t;
endpackage

// File: rtl/usc_sync.sv
module usc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], din};
  end
  assign dout = chain[STAGES-1];
endmodule

// File: rtl/usc_datapath.sv
module usc_datapath
  import usc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IMG_W  = 640,
  parameter int IMG_H  = 480,
  parameter bit GRAY   = 1'b1
) (
  input  logic [DATA_W-1:0] busDataIn,
  input  logic [DATA_W-1:0] fifoData,
  input  dpCtrl_t           dpCtrl,
  output cmdKind_t          cmdKind,
  output logic [DATA_W-1:0] busDataOut
);
  localparam logic [7:0] TYPE_CODE = GRAY ? 8'hAA : 8'hBB;
  localparam int PAD_W = DATA_W - 8;

  logic [DATA_W-1:0] replyWord;

  always_comb begin
    if (busDataIn == CODE_QUERY)      cmdKind = CMD_QUERY;
    else if (busDataIn == CODE_START) cmdKind = CMD_START;
    else if (busDataIn == CODE_STOP)  cmdKind = CMD_STOP;
    else                              cmdKind = CMD_NONE;
  end

  always_comb begin
    case (dpCtrl.wordSel)
      2'd0:    replyWord = {{PAD_W{1'b0}}, TYPE_CODE};
      2'd1:    replyWord = DATA_W'(IMG_W);
      2'd2:    replyWord = DATA_W'(IMG_H);
      default: replyWord = '0;
    endcase
  end

  always_comb begin
    if (dpCtrl.sendPixel)      busDataOut = fifoData;
    else if (dpCtrl.sendReply) busDataOut = replyWord;
    else                       busDataOut = '0;
  end
endmodule

// File: rtl/usc_control.sv
module usc_control
  import usc_pkg::*;
#(
  parameter int FLAG_LAT = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     notEmpty,
  input  logic     notFull,
  input  logic     fifoEmpty,
  input  cmdKind_t cmdKind,
  output logic     rdEn,
  output logic     wrEn,
  output logic     fifoRd,
  output logic     streamReq,
  output dpCtrl_t  dpCtrl
);
  localparam logic [1:0] LAST_WORD = 2'(REPLY_WORDS - 1);

  ctrlState_t        state;
  logic [1:0]        wordCnt;
  logic              streamOn;
  logic [FLAG_LAT-1:0] nfHist;
  logic              okWrite, replyWr, pixWr;

  assign okWrite = notFull & (&nfHist);
  assign rdEn    = (state != S_REPLY) && notEmpty;
  assign replyWr = (state == S_REPLY) && okWrite;
  assign pixWr   = (state == S_STREAM) && !notEmpty && okWrite && !fifoEmpty;
  assign wrEn    = replyWr | pixWr;
  assign fifoRd  = pixWr;
  assign streamReq = streamOn;

  always_comb begin
    dpCtrl.sendReply = replyWr;
    dpCtrl.wordSel   = wordCnt;
    dpCtrl.sendPixel = pixWr;
  end

  generate
    if (FLAG_LAT == 1) begin : g_hist1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) nfHist <= '0;
        else       nfHist <= notFull;
      end
    end else begin : g_histN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) nfHist <= '0;
        else       nfHist <= {nfHist[FLAG_LAT-2:0], notFull};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_WAIT;
      wordCnt  <= '0;
      streamOn <= 1'b0;
    end else if (rdEn) begin
      case (cmdKind)
        CMD_QUERY: begin
          state   <= S_REPLY;
          wordCnt <= '0;
        end
        CMD_START: begin
          streamOn <= 1'b1;
          state    <= S_STREAM;
        end
        CMD_STOP: begin
          streamOn <= 1'b0;
          state    <= S_WAIT;
        end
        default: ;
      endcase
    end else if (replyWr) begin
      if (wordCnt == LAST_WORD) begin
        wordCnt <= '0;
        state   <= streamOn ? S_STREAM : S_WAIT;
      end else begin
        wordCnt <= wordCnt + 2'd1;
      end
    end
  end
endmodule

// File: rtl/usb_stream_ctrl.sv
module usb_stream_ctrl
  import usc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int IMG_W    = 640,
  parameter int IMG_H    = 480,
  parameter bit GRAY     = 1'b1,
  parameter int FLAG_LAT = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              notEmpty,
  input  logic              notFull,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              rdEn,
  output logic              wrEn,
  output logic [DATA_W-1:0] busDataOut,
  input  logic [DATA_W-1:0] fifoData,
  input  logic              fifoEmpty,
  output logic              fifoRd,
  output logic              streamReq,
  input  logic              pixClk,
  input  logic              pixRstN,
  output logic              streamStartPix
);
  cmdKind_t cmdKind;
  dpCtrl_t  dpCtrl;

  usc_control #(.FLAG_LAT(FLAG_LAT)) u_ctrl (
    .clk(clk), .rstN(rstN), .notEmpty(notEmpty), .notFull(notFull),
    .fifoEmpty(fifoEmpty), .cmdKind(cmdKind), .rdEn(rdEn), .wrEn(wrEn),
    .fifoRd(fifoRd), .streamReq(streamReq), .dpCtrl(dpCtrl)
  );

  usc_datapath #(.DATA_W(DATA_W), .IMG_W(IMG_W), .IMG_H(IMG_H), .GRAY(GRAY)) u_dp (
    .busDataIn(busDataIn), .fifoData(fifoData), .dpCtrl(dpCtrl),
    .cmdKind(cmdKind), .busDataOut(busDataOut)
  );

  usc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(pixClk), .rstN(pixRstN), .din(streamReq), .dout(streamStartPix)
  );
endmodule

// File: rtl/usc_checker.sv
module usc_checker (
  input logic clk,
  input logic rstN,
  input logic notEmpty,
  input logic notFull,
  input logic fifoEmpty,
  input logic rdEn,
  input logic wrEn,
  input logic fifoRd,
  input logic streamReq
);
  p_read_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> notEmpty);

  p_write_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (notFull && $past(notFull) && $past(notFull, 2)));

  p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && wrEn));

  p_pixel_pop_r6: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |-> (wrEn && !fifoEmpty));

  p_req_by_cmd_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(streamReq) |-> $past(rdEn));
endmodule

bind usb_stream_ctrl usc_checker u_chk (
  .clk(clk), .rstN(rstN), .notEmpty(notEmpty), .notFull(notFull),
  .fifoEmpty(fifoEmpty), .rdEn(rdEn), .wrEn(wrEn), .fifoRd(fifoRd),
  .streamReq(streamReq)
);

// File: tb/sim_usb_stream_ctrl.sv
module sim_usb_stream_ctrl;
  localparam int W = 320;
  localparam int H = 240;
  localparam bit GRAY = 1'b0;
  localparam logic [15:0] TYPE_WORD = GRAY ? 16'h00AA : 16'h00BB;

  logic clk = 1'b0, pixClk = 1'b0, rstN = 1'b0;
  logic notEmpty = 1'b0, notFull = 1'b0, fifoEmpty = 1'b1;
  logic [15:0] busDataIn = '0, fifoData = '0;
  logic rdEn, wrEn, fifoRd, streamReq, streamStartPix;
  logic [15:0] busDataOut;

  always #2 clk = ~clk;
  always #3.5 pixClk = ~pixClk;

  usb_stream_ctrl #(.IMG_W(W), .IMG_H(H), .GRAY(GRAY)) u0 (
    .clk(clk), .rstN(rstN), .notEmpty(notEmpty), .notFull(notFull),
    .busDataIn(busDataIn), .rdEn(rdEn), .wrEn(wrEn), .busDataOut(busDataOut),
    .fifoData(fifoData), .fifoEmpty(fifoEmpty), .fifoRd(fifoRd),
    .streamReq(streamReq), .pixClk(pixClk), .pixRstN(rstN),
    .streamStartPix(streamStartPix)
  );

  int errors = 0, checks = 0;
  logic [15:0] hostQ[$], pixQ[$], outQ[$];
  int nfMode = 0;   // 0 always ready, 1 random, 2 never ready
  int neMode = 0;   // 0 steady, 1 randomly gated
  // behavioural model: 0 waiting, 1 replying, 2 streaming
  int mState = 0, mIdx = 0;
  bit mStream = 0, h1 = 0, h2 = 0;
  bit done = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cycle();
    bit eRd, eWr, eFr, okW;
    logic [15:0] eData;
    @(negedge clk);
    notFull  = (nfMode == 0) ? 1'b1 : (nfMode == 2) ? 1'b0 : ($urandom_range(0, 3) != 0);
    notEmpty = (hostQ.size() > 0) && (neMode == 0 || $urandom_range(0, 1) == 1);
    busDataIn = (hostQ.size() > 0) ? hostQ[0] : 16'h0;
    fifoEmpty = (pixQ.size() == 0);
    fifoData  = (pixQ.size() > 0) ? pixQ[0] : 16'h0;
    #1;
    okW = notFull && h1 && h2;
    eRd = (mState != 1) && notEmpty;
    eWr = 0; eFr = 0; eData = 16'h0;
    if (mState == 1 && okW) begin
      eWr = 1;
      eData = (mIdx == 0) ? TYPE_WORD : (mIdx == 1) ? 16'(W) : 16'(H);
    end else if (mState == 2 && !notEmpty && okW && !fifoEmpty) begin
      eWr = 1; eFr = 1; eData = fifoData;
    end
    chk(rdEn == eRd, "R1", "rdEn", rdEn, eRd);
    chk(wrEn == eWr, "R3", "wrEn", wrEn, eWr);
    chk(fifoRd == eFr, "R6", "fifoRd", fifoRd, eFr);
    chk(busDataOut == eData, "R11", "busDataOut", busDataOut, eData);
    chk(streamReq == mStream, "R4", "streamReq", streamReq, mStream);
    // advance the model and the bridge/FIFO models to the next edge
    if (eRd) begin
      void'(hostQ.pop_front());
      case (busDataIn)
        16'h0101: begin mState = 1; mIdx = 0; end
        16'h1111: begin mStream = 1; mState = 2; end
        16'h0f0f: begin mStream = 0; mState = 0; end
        default: ;
      endcase
    end else if (eWr && mState == 1) begin
      if (mIdx == 2) begin mIdx = 0; mState = mStream ? 2 : 0; end
      else mIdx++;
    end
    if (eFr) void'(pixQ.pop_front());
    if (wrEn) outQ.push_back(busDataOut);
    h2 = h1; h1 = notFull;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic expectReply(string req);
    chk(outQ.size() == 3, req, "reply length", outQ.size(), 3);
    if (outQ.size() == 3) begin
      chk(outQ[0] == TYPE_WORD, "R2", "type word", outQ[0], TYPE_WORD);
      chk(outQ[0][7:0] == 8'hBB, "R2", "first byte", outQ[0][7:0], 8'hBB);
      chk(outQ[1] == 16'(W), "R2", "width word", outQ[1], W);
      chk(outQ[2] == 16'(H), "R2", "height word", outQ[2], H);
    end
    outQ.delete();
  endtask

  initial begin
    run(0);
    repeat (4) @(negedge clk);
    #1;
    chk(rdEn == 0 && wrEn == 0 && fifoRd == 0, "R10", "strobes in reset", {rdEn, wrEn, fifoRd}, 0);
    chk(streamReq == 0 && streamStartPix == 0, "R10", "stream in reset", {streamReq, streamStartPix}, 0);
    chk(busDataOut == 0, "R10", "bus in reset", busDataOut, 0);
    @(negedge clk); rstN = 1'b1;
    run(3);

    // R2: query with a ready bridge
    hostQ.push_back(16'h0101); run(10);
    expectReply("R2");

    // R3 / R11: query with a toggling not-full flag, commands waiting behind it
    nfMode = 1;
    hostQ.push_back(16'h0101); hostQ.push_back(16'h1234); run(60);
    chk(hostQ.size() == 0, "R11", "queue drained", hostQ.size(), 0);
    expectReply("R3");

    // R5: unknown words then stop while idle
    nfMode = 0;
    hostQ.push_back(16'hBEEF); hostQ.push_back(16'h1110); hostQ.push_back(16'h0f0f); run(10);
    chk(outQ.size() == 0, "R5", "no writes", outQ.size(), 0);
    chk(streamReq == 0, "R5", "stream stays off", streamReq, 0);

    // R6: pixels present while off are not sent
    for (int i = 0; i < 8; i++) pixQ.push_back(16'hA000 + 16'(i));
    run(8);
    chk(outQ.size() == 0, "R6", "no pixel while off", outQ.size(), 0);

    // R4 / R6 / R9: start streaming
    hostQ.push_back(16'h1111); run(20);
    chk(streamReq == 1, "R4", "start sets request", streamReq, 1);
    chk(streamStartPix == 1, "R9", "pixel-domain request", streamStartPix, 1);
    chk(outQ.size() == 8, "R6", "pixel count", outQ.size(), 8);
    for (int i = 0; i < 8 && i < outQ.size(); i++)
      chk(outQ[i] == 16'hA000 + 16'(i), "R6", "pixel order", outQ[i], 16'hA000 + i);
    outQ.delete();

    // R7 / R8: commands mixed into the pixel flow, random flags
    nfMode = 1; neMode = 1;
    for (int i = 0; i < 40; i++) pixQ.push_back(16'hC000 + 16'(i));
    hostQ.push_back(16'h1111); hostQ.push_back(16'h0101);
    run(200);
    chk(pixQ.size() == 0, "R8", "stream resumed after reply", pixQ.size(), 0);
    chk(outQ.size() == 43, "R8", "words out", outQ.size(), 43);

    // R4: stop, then pixels must stay put
    outQ.delete(); neMode = 0; nfMode = 0;
    hostQ.push_back(16'h0f0f); run(4);
    for (int i = 0; i < 4; i++) pixQ.push_back(16'hD000 + 16'(i));
    run(20);
    chk(streamReq == 0, "R4", "stop clears request", streamReq, 0);
    chk(streamStartPix == 0, "R9", "pixel-domain clear", streamStartPix, 0);
    chk(outQ.size() == 0, "R6", "no pixel after stop", outQ.size(), 0);

    // R3: bridge full holds everything
    nfMode = 2; hostQ.push_back(16'h0101); run(20);
    chk(outQ.size() == 0, "R3", "no write while full", outQ.size(), 0);
    nfMode = 0; run(10);
    expectReply("R3");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule